// File: doc/BRIEF.md
# Inter-Processor Doorbell and Message Interrupt Unit

This block lets software on one processor ring numbered doorbells on any set of processors, and it gives message-signalled interrupts a place to land. One write to a single software-interrupt register carries both a bitmap of target processors and a doorbell number. When a flag bit is set in that write, the write instead sets a bit in a shared message cause register, and the low bits are the message vector. Every processor has a doorbell cause register and a doorbell mask register. A processor's interrupt line is high while any pending doorbell is also enabled in its mask. A separate message output is high while any message vector is pending.

Writes arrive on two ports. The register port (`reg_*`) reaches every register. The inbound message port (`msg_*`) carries only data for the software-interrupt register, as an endpoint's message write does. Both ports may act in the same cycle. Pending bits are cleared by writing the cause register with zeros in the bits to clear and ones everywhere else. If a new event and a clear hit the same bit in the same cycle, the new event wins. Reads on the register port are combinational from `reg_rgn` and `reg_addr`.

The write decoder sorts each write into one of six named operations: OP_IDLE (no effect), OP_RING (set a doorbell on the target processors), OP_MSI_SET (set a message vector), OP_CAUSE_WR (clear doorbells of one processor), OP_MASK_WR (load one processor's mask) and OP_MSI_WR (clear message vectors). All state sits in plain registers with no sequencing. The next value of each register follows from the operations decoded in the current cycle.

Top module: `dbu_doorbell_unit`

## Requirements
- R1: After reset, every doorbell cause register, every mask register and the message cause register read 0, and `db_irq` and `msi_irq` are low.
- R2: A register-port write with `reg_rgn`=0, `reg_addr`=0x004, bit 5 clear and bits 7:6 zero sets doorbell bit `wdata[4:0]` in every processor i whose `wdata[8+i]` is 1. All selected processors change in the same cycle, and unselected processors do not change.
- R3: A software-interrupt write with bit 5 clear is ignored if bits 7:6 are not zero or if the doorbell number is not below the number of doorbells.
- R4: A software-interrupt write with bit 5 set, on either port, sets message cause bit `wdata[4:0]`. The processor bitmap in that write is ignored.
- R5: A register-port write to region 1 at address {cpu, 0x08}, with cpu in `reg_addr[11:8]`, clears each cause bit of that processor written as 0 and keeps each bit written as 1.
- R6: If a set event and a clear hit the same cause bit in the same cycle, the bit ends up set. This holds for doorbells and for message vectors.
- R7: A write to region 1 at address {cpu, 0x0C} loads that processor's mask register, and a read returns the stored value.
- R8: `db_irq[i]` is high exactly when processor i has a cause bit that is set and also enabled in its mask.
- R9: `msi_irq` is high exactly when at least one message cause bit is set.
- R10: A register-port write to region 2 at address 0x000 clears each message cause bit written as 0 and keeps each bit written as 1.
- R11: Reads return cause (offset 0x08) and mask (offset 0x0C) for region 1, and the message cause register for region 2 at address 0. All other addresses, and processor indexes at or above the processor count, read 0 and ignore writes.
- R12: In a cycle with no write on either port, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register-port write strobe |
| reg_rgn | input | 2 | Region: 0 global, 1 per-processor, 2 message cause, 3 none |
| reg_addr | input | AW | Address within region, per-processor index in bits 11:8 |
| reg_wdata | input | DW | Register-port write data |
| reg_rdata | output | DW | Combinational read data for `reg_rgn`/`reg_addr` |
| msg_valid | input | 1 | Inbound message write to the software-interrupt register |
| msg_data | input | DW | Inbound message write data |
| db_irq | output | NCPU | Per-processor doorbell interrupt |
| msi_irq | output | 1 | Message interrupt |

## Verification
On every cycle, the assertions check the following: a ring or message write sets the named bit one cycle later, writes with reserved bits set leave every cause register unchanged, a clear drops exactly the bits written as zero, a set wins over a same-cycle clear, and no register moves in an idle cycle. Only the bench's scenarios can show the rest. They show that two processors pick up one doorbell in the same cycle and that masks gate each interrupt line separately. They also show that writes to processor indexes with no processor, and to unmapped addresses, read back as nothing.

// File: rtl/dbu_pkg.sv
`timescale 1ns/1ps
package dbu_pkg;

    typedef enum logic [1:0] {
        RGN_GLOBAL = 2'd0,
        RGN_CPU    = 2'd1,
        RGN_MSI    = 2'd2,
        RGN_NONE   = 2'd3
    } dbu_rgn_e;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_RING     = 3'd1,
        OP_MSI_SET  = 3'd2,
        OP_CAUSE_WR = 3'd3,
        OP_MASK_WR  = 3'd4,
        OP_MSI_WR   = 3'd5
    } dbu_op_e;

    // register offsets
    localparam logic [7:0] OFS_SWINT     = 8'h04;
    localparam logic [7:0] OFS_CAUSE     = 8'h08;
    localparam logic [7:0] OFS_MASK      = 8'h0C;
    localparam logic [7:0] OFS_MSI_CAUSE = 8'h00;

    // software-interrupt write field layout
    localparam int NUM_W          = 5;
    localparam int MSI_FLAG_BIT   = 5;
    localparam int RESV_LSB       = 6;
    localparam int RESV_W         = 2;
    localparam int TGT_LSB        = 8;
    localparam int CPU_STRIDE_LSB = 8;

endpackage

// File: rtl/dbu_wr_decode.sv
`timescale 1ns/1ps
module dbu_wr_decode
    import dbu_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NDB  = 32,
    parameter int NMSI = 32,
    parameter int AW   = 12,
    parameter int DW   = 32
) (
    input  logic            wr,
    input  logic [1:0]      rgn,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output dbu_op_e         op,
    output logic [NUM_W-1:0] num,
    output logic [NCPU-1:0] tgt,
    output logic [NCPU-1:0] cpu_sel
);
    localparam int CIDX_W = AW - CPU_STRIDE_LSB;

    logic [CIDX_W-1:0] cidx;
    logic [7:0]        ofs;
    logic              flag;
    logic              resv_clr;
    logic              num_ok_db;
    logic              num_ok_msi;
    logic              cidx_ok;
    logic              unused_hi;

    assign cidx       = addr[AW-1:CPU_STRIDE_LSB];
    assign ofs        = addr[7:0];
    assign num        = wdata[NUM_W-1:0];
    assign flag       = wdata[MSI_FLAG_BIT];
    assign resv_clr   = (wdata[RESV_LSB +: RESV_W] == '0);
    assign tgt        = wdata[TGT_LSB +: NCPU];
    assign num_ok_db  = (int'(num) < NDB);
    assign num_ok_msi = (int'(num) < NMSI);
    assign cidx_ok    = (int'(cidx) < NCPU);
    assign unused_hi  = ^wdata[DW-1:TGT_LSB+NCPU];

    always_comb begin
        op = OP_IDLE;
        if (wr) begin
            unique case (dbu_rgn_e'(rgn))
                RGN_GLOBAL: begin
                    if (addr == AW'(OFS_SWINT)) begin
                        if (flag) begin
                            if (num_ok_msi) op = OP_MSI_SET;
                        end else if (resv_clr && num_ok_db) begin
                            op = OP_RING;
                        end
                    end
                end
                RGN_CPU: begin
                    if (cidx_ok) begin
                        if (ofs == OFS_CAUSE)     op = OP_CAUSE_WR;
                        else if (ofs == OFS_MASK) op = OP_MASK_WR;
                    end
                end
                RGN_MSI: begin
                    if (addr == AW'(OFS_MSI_CAUSE)) op = OP_MSI_WR;
                end
                default: op = OP_IDLE;
            endcase
        end
    end

    always_comb begin
        for (int k = 0; k < NCPU; k++) begin
            cpu_sel[k] = (int'(cidx) == k);
        end
    end

endmodule

// File: rtl/dbu_cpu_bank.sv
`timescale 1ns/1ps
module dbu_cpu_bank #(
    parameter int NDB = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NDB-1:0] set_vec,
    input  logic           clr_en,
    input  logic [NDB-1:0] keep,
    input  logic           mask_we,
    input  logic [NDB-1:0] mask_d,
    output logic [NDB-1:0] cause,
    output logic [NDB-1:0] mask,
    output logic           irq
);
    logic [NDB-1:0] cause_base;

    // clear applies first, set is ORed afterwards so it wins
    assign cause_base = clr_en ? (cause & keep) : cause;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause <= '0;
            mask  <= '0;
        end else begin
            cause <= cause_base | set_vec;
            if (mask_we) mask <= mask_d;
        end
    end

    assign irq = |(cause & mask);

endmodule

// File: rtl/dbu_msi_cause.sv
`timescale 1ns/1ps
module dbu_msi_cause #(
    parameter int NMSI = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NMSI-1:0] set_vec,
    input  logic            clr_en,
    input  logic [NMSI-1:0] keep,
    output logic [NMSI-1:0] cause,
    output logic            irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause <= '0;
        end else if (clr_en) begin
            cause <= (cause & keep) | set_vec;
        end else begin
            cause <= cause | set_vec;
        end
    end

    assign irq = |cause;

endmodule

// File: rtl/dbu_doorbell_unit.sv
`timescale 1ns/1ps
module dbu_doorbell_unit
    import dbu_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NDB  = 32,
    parameter int NMSI = 32,
    parameter int AW   = 12,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_rgn,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            msg_valid,
    input  logic [DW-1:0]   msg_data,
    output logic [NCPU-1:0] db_irq,
    output logic            msi_irq
);
    localparam int CIDX_W = AW - CPU_STRIDE_LSB;

    dbu_op_e          op_a, op_b;
    logic [NUM_W-1:0] num_a, num_b;
    logic [NCPU-1:0]  tgt_a, tgt_b;
    logic [NCPU-1:0]  sel_a;
    logic [NCPU-1:0]  unused_sel_b;

    logic [NDB-1:0]   hot_a, hot_b;
    logic [NMSI-1:0]  mhot_a, mhot_b;

    logic [NCPU-1:0][NDB-1:0] cause_all;
    logic [NCPU-1:0][NDB-1:0] mask_all;
    logic [NMSI-1:0]          msi_cause;

    dbu_wr_decode #(.NCPU(NCPU), .NDB(NDB), .NMSI(NMSI), .AW(AW), .DW(DW)) dec_a (
        .wr(reg_wr), .rgn(reg_rgn), .addr(reg_addr), .wdata(reg_wdata),
        .op(op_a), .num(num_a), .tgt(tgt_a), .cpu_sel(sel_a)
    );

    // message port only ever reaches the software-interrupt register
    dbu_wr_decode #(.NCPU(NCPU), .NDB(NDB), .NMSI(NMSI), .AW(AW), .DW(DW)) dec_b (
        .wr(msg_valid), .rgn(2'(RGN_GLOBAL)), .addr(AW'(OFS_SWINT)), .wdata(msg_data),
        .op(op_b), .num(num_b), .tgt(tgt_b), .cpu_sel(unused_sel_b)
    );

    assign hot_a  = (op_a == OP_RING)    ? (NDB'(1)  << num_a) : '0;
    assign hot_b  = (op_b == OP_RING)    ? (NDB'(1)  << num_b) : '0;
    assign mhot_a = (op_a == OP_MSI_SET) ? (NMSI'(1) << num_a) : '0;
    assign mhot_b = (op_b == OP_MSI_SET) ? (NMSI'(1) << num_b) : '0;

    generate
        for (genvar k = 0; k < NCPU; k++) begin : g_cpu
            logic [NDB-1:0] set_k;
            assign set_k = (tgt_a[k] ? hot_a : '0) | (tgt_b[k] ? hot_b : '0);

            dbu_cpu_bank #(.NDB(NDB)) bank_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_vec (set_k),
                .clr_en  ((op_a == OP_CAUSE_WR) && sel_a[k]),
                .keep    (reg_wdata[NDB-1:0]),
                .mask_we ((op_a == OP_MASK_WR) && sel_a[k]),
                .mask_d  (reg_wdata[NDB-1:0]),
                .cause   (cause_all[k]),
                .mask    (mask_all[k]),
                .irq     (db_irq[k])
            );
        end
    endgenerate

    dbu_msi_cause #(.NMSI(NMSI)) msi_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (mhot_a | mhot_b),
        .clr_en  (op_a == OP_MSI_WR),
        .keep    (reg_wdata[NMSI-1:0]),
        .cause   (msi_cause),
        .irq     (msi_irq)
    );

    // read side
    logic [CIDX_W-1:0] rd_cidx;
    logic [7:0]        rd_ofs;
    assign rd_cidx = reg_addr[AW-1:CPU_STRIDE_LSB];
    assign rd_ofs  = reg_addr[7:0];

    always_comb begin
        reg_rdata = '0;
        unique case (dbu_rgn_e'(reg_rgn))
            RGN_CPU: begin
                for (int k = 0; k < NCPU; k++) begin
                    if (int'(rd_cidx) == k) begin
                        if (rd_ofs == OFS_CAUSE)     reg_rdata = DW'(cause_all[k]);
                        else if (rd_ofs == OFS_MASK) reg_rdata = DW'(mask_all[k]);
                    end
                end
            end
            RGN_MSI: begin
                if (reg_addr == AW'(OFS_MSI_CAUSE)) reg_rdata = DW'(msi_cause);
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbu_doorbell_unit_chk.sv
`timescale 1ns/1ps
module dbu_doorbell_unit_chk
    import dbu_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NDB  = 32,
    parameter int NMSI = 32,
    parameter int AW   = 12,
    parameter int DW   = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [1:0]               reg_rgn,
    input logic [AW-1:0]            reg_addr,
    input logic [DW-1:0]            reg_wdata,
    input logic                     msg_valid,
    input logic [DW-1:0]            msg_data,
    input logic [NCPU-1:0]          db_irq,
    input logic                     msi_irq,
    input logic [NCPU-1:0][NDB-1:0] cause_all,
    input logic [NCPU-1:0][NDB-1:0] mask_all,
    input logic [NMSI-1:0]          msi_cause
);
    logic a_sw, a_ring, a_resv, b_ring, b_msi;
    assign a_sw   = reg_wr && (reg_rgn == 2'd0) && (reg_addr == AW'(OFS_SWINT));
    assign a_ring = a_sw && !reg_wdata[MSI_FLAG_BIT] && (reg_wdata[RESV_LSB +: RESV_W] == '0)
                    && (int'(reg_wdata[NUM_W-1:0]) < NDB);
    assign a_resv = a_sw && !reg_wdata[MSI_FLAG_BIT] && (reg_wdata[RESV_LSB +: RESV_W] != '0);
    assign b_ring = msg_valid && !msg_data[MSI_FLAG_BIT] && (msg_data[RESV_LSB +: RESV_W] == '0)
                    && (int'(msg_data[NUM_W-1:0]) < NDB);
    assign b_msi  = msg_valid && msg_data[MSI_FLAG_BIT] && (int'(msg_data[NUM_W-1:0]) < NMSI);

    generate
        for (genvar k = 0; k < NCPU; k++) begin : g_k
            AST_RING_SETS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
                (a_ring && reg_wdata[TGT_LSB+k]) |=> cause_all[k][$past(reg_wdata[NUM_W-1:0])]); // R2

            AST_MSG_RING_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (b_ring && msg_data[TGT_LSB+k]) |=> cause_all[k][$past(msg_data[NUM_W-1:0])]); // R6

            AST_CLEAR_DROPS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_wr && reg_rgn == 2'd1 && reg_addr == AW'(k*256 + 8) && !msg_valid)
                |=> ((cause_all[k] & ~$past(reg_wdata[NDB-1:0])) == '0)); // R5

            AST_IRQ_RISES_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(db_irq[k]) |-> $past(reg_wr || msg_valid)); // R8
        end
    endgenerate

    AST_MSG_SETS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        b_msi |=> msi_cause[$past(msg_data[NUM_W-1:0])]); // R4

    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (a_resv && !msg_valid) |=> $stable(cause_all)); // R3

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !msg_valid) |=> ($stable(cause_all) && $stable(mask_all) && $stable(msi_cause))); // R12

    AST_MSI_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msi_irq) |-> $past(reg_wr && reg_rgn == 2'd2)); // R10

endmodule

bind dbu_doorbell_unit dbu_doorbell_unit_chk #(
    .NCPU(NCPU), .NDB(NDB), .NMSI(NMSI), .AW(AW), .DW(DW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rgn   (reg_rgn),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .msg_valid (msg_valid),
    .msg_data  (msg_data),
    .db_irq    (db_irq),
    .msi_irq   (msi_irq),
    .cause_all (cause_all),
    .mask_all  (mask_all),
    .msi_cause (msi_cause)
);

// File: tb/dbu_doorbell_unit_tb_top.sv
`timescale 1ns/1ps
module dbu_doorbell_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_rgn = 2'd3;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid = 1'b0;
    logic [31:0] msg_data = '0;
    logic [3:0]  db_irq;
    logic        msi_irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dbu_doorbell_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rgn(reg_rgn), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_data(msg_data),
        .db_irq(db_irq), .msi_irq(msi_irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cause [4];
    logic [31:0] m_mask  [4];
    logic [31:0] m_msi;
    logic [31:0] s_cpu   [4];
    logic [31:0] s_msi;

    task automatic model_sw_write(input logic [31:0] d);
        if (d[5]) s_msi = s_msi | (32'd1 << d[4:0]);
        else if (d[7:6] == 2'b00) begin
            for (int c = 0; c < 4; c++)
                if (d[8+c]) s_cpu[c] = s_cpu[c] | (32'd1 << d[4:0]);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin m_cause[c] = '0; m_mask[c] = '0; end
            m_msi = '0;
        end else begin
            for (int c = 0; c < 4; c++) s_cpu[c] = '0;
            s_msi = '0;
            if (msg_valid) model_sw_write(msg_data);
            if (reg_wr) begin
                if (reg_rgn == 2'd0 && reg_addr == 12'h004) model_sw_write(reg_wdata);
                if (reg_rgn == 2'd1 && int'(reg_addr[11:8]) < 4) begin
                    if (reg_addr[7:0] == 8'h08) m_cause[reg_addr[9:8]] = m_cause[reg_addr[9:8]] & reg_wdata;
                    if (reg_addr[7:0] == 8'h0C) m_mask[reg_addr[9:8]] = reg_wdata;
                end
                if (reg_rgn == 2'd2 && reg_addr == 12'h000) m_msi = m_msi & reg_wdata;
            end
            for (int c = 0; c < 4; c++) m_cause[c] = m_cause[c] | s_cpu[c];
            m_msi = m_msi | s_msi;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [1:0] rg, input logic [11:0] ad);
        if (rg == 2'd1 && int'(ad[11:8]) < 4) begin
            if (ad[7:0] == 8'h08) return m_cause[ad[9:8]];
            if (ad[7:0] == 8'h0C) return m_mask[ad[9:8]];
        end
        if (rg == 2'd2 && ad == 12'h000) return m_msi;
        return 32'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_cycle();
        logic [3:0] e_irq;
        for (int c = 0; c < 4; c++) e_irq[c] = |(m_cause[c] & m_mask[c]);
        chk("R8 model db_irq", 32'(db_irq), 32'(e_irq));
        chk("R9 model msi_irq", 32'(msi_irq), 32'(|m_msi));
        chk("R11 model rdata", reg_rdata, exp_rd(reg_rgn, reg_addr));
    endtask

    // all stimulus passes through here: compare on the falling edge, then drive
    task automatic drive(input logic wr, input logic [1:0] rg, input logic [11:0] ad,
                         input logic [31:0] d, input logic mv, input logic [31:0] md);
        @(negedge clk);
        if (rst_n) compare_cycle();
        reg_wr = wr; reg_rgn = rg; reg_addr = ad; reg_wdata = d;
        msg_valid = mv; msg_data = md;
    endtask

    task automatic wr_a(input logic [1:0] rg, input logic [11:0] ad, input logic [31:0] d);
        drive(1'b1, rg, ad, d, 1'b0, 32'd0);
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] rg, input logic [11:0] ad,
                          input logic [31:0] exp);
        drive(1'b0, rg, ad, 32'd0, 1'b0, 32'd0);
        #2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic irq_chk(input string tag, input logic [3:0] e_db, input logic e_msi);
        #1;
        chk({tag, " db_irq"}, 32'(db_irq), 32'(e_db));
        chk({tag, " msi_irq"}, 32'(msi_irq), 32'(e_msi));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < 4; c++) begin
            rd_chk("R1 cause after reset", 2'd1, 12'(c*256 + 8), 32'd0);
            rd_chk("R1 mask after reset", 2'd1, 12'(c*256 + 12), 32'd0);
        end
        rd_chk("R1 msi cause after reset", 2'd2, 12'h000, 32'd0);
        irq_chk("R1", 4'b0000, 1'b0);

        // R7 mask loads
        wr_a(2'd1, 12'h00C, 32'hFFFF_FFFF);
        wr_a(2'd1, 12'h10C, 32'h0000_00F0);
        wr_a(2'd1, 12'h20C, 32'hFFFF_FFFF);
        wr_a(2'd1, 12'h30C, 32'h0000_0000);
        rd_chk("R7 mask cpu1", 2'd1, 12'h10C, 32'h0000_00F0);
        rd_chk("R7 mask cpu2", 2'd1, 12'h20C, 32'hFFFF_FFFF);

        // R2 ring doorbell 3 on cpus 0 and 2 together
        wr_a(2'd0, 12'h004, 32'h0000_0503);
        rd_chk("R2 cause cpu0", 2'd1, 12'h008, 32'h0000_0008);
        irq_chk("R2 R8 both targets", 4'b0101, 1'b0);
        rd_chk("R2 cause cpu1 untouched", 2'd1, 12'h108, 32'd0);
        rd_chk("R2 cause cpu2", 2'd1, 12'h208, 32'h0000_0008);
        rd_chk("R2 cause cpu3 untouched", 2'd1, 12'h308, 32'd0);

        // R8 doorbell 5 on cpus 1 and 3, cpu3 fully masked
        wr_a(2'd0, 12'h004, 32'h0000_0A05);
        rd_chk("R8 cause cpu3", 2'd1, 12'h308, 32'h0000_0020);
        irq_chk("R8 mask gating", 4'b0111, 1'b0);

        // R3 reserved bits set: ignored
        wr_a(2'd0, 12'h004, 32'h0000_0F42);
        rd_chk("R3 cause cpu0 unchanged", 2'd1, 12'h008, 32'h0000_0008);
        rd_chk("R3 cause cpu3 unchanged", 2'd1, 12'h308, 32'h0000_0020);

        // R4 MSI via message port, cpu bitmap ignored
        drive(1'b0, 2'd3, 12'h000, 32'd0, 1'b1, 32'h0000_0F27);
        rd_chk("R4 msi cause", 2'd2, 12'h000, 32'h0000_0080);
        irq_chk("R4 R9", 4'b0111, 1'b1);
        rd_chk("R4 cpu0 not rung", 2'd1, 12'h008, 32'h0000_0008);

        // R4 MSI via register port
        wr_a(2'd0, 12'h004, 32'h0000_003F);
        rd_chk("R4 msi vector 31", 2'd2, 12'h000, 32'h8000_0080);

        // R5 clear cpu0 bit 3
        wr_a(2'd1, 12'h008, 32'hFFFF_FFF7);
        rd_chk("R5 cpu0 cleared", 2'd1, 12'h008, 32'd0);
        irq_chk("R5 R8", 4'b0110, 1'b1);
        rd_chk("R5 cpu2 kept", 2'd1, 12'h208, 32'h0000_0008);

        // R6 set beats clear on the same bit
        drive(1'b1, 2'd1, 12'h208, 32'hFFFF_FFF7, 1'b1, 32'h0000_0403);
        rd_chk("R6 cpu2 bit stays set", 2'd1, 12'h208, 32'h0000_0008);
        drive(1'b1, 2'd1, 12'h108, 32'hFFFF_FFDF, 1'b1, 32'h0000_0209);
        rd_chk("R6 cpu1 clear and ring", 2'd1, 12'h108, 32'h0000_0200);
        irq_chk("R6 R8 cpu1 masked out", 4'b0100, 1'b1);

        // R10 MSI clear
        wr_a(2'd2, 12'h000, 32'h8000_0000);
        rd_chk("R10 msi partial clear", 2'd2, 12'h000, 32'h8000_0000);
        wr_a(2'd2, 12'h000, 32'h0000_0000);
        rd_chk("R10 msi cleared", 2'd2, 12'h000, 32'd0);
        irq_chk("R10 R9", 4'b0100, 1'b0);
        drive(1'b1, 2'd2, 12'h000, 32'h0000_0000, 1'b1, 32'h0000_0024);
        rd_chk("R6 msi set beats clear", 2'd2, 12'h000, 32'h0000_0010);

        // R11 absent processor and unmapped addresses
        wr_a(2'd1, 12'h40C, 32'hFFFF_FFFF);
        rd_chk("R11 cpu4 mask reads 0", 2'd1, 12'h40C, 32'd0);
        wr_a(2'd1, 12'h308, 32'h0000_0000);
        rd_chk("R11 sanity clear cpu3", 2'd1, 12'h308, 32'd0);
        rd_chk("R11 global swint reads 0", 2'd0, 12'h004, 32'd0);
        rd_chk("R11 unmapped per-cpu ofs", 2'd1, 12'h010, 32'd0);
        rd_chk("R11 region 3 reads 0", 2'd3, 12'h008, 32'd0);

        // R12 idle cycles keep state
        for (int i = 0; i < 5; i++) drive(1'b0, 2'd3, 12'h000, 32'd0, 1'b0, 32'd0);
        rd_chk("R12 cpu2 held", 2'd1, 12'h208, 32'h0000_0008);
        rd_chk("R12 cpu1 held", 2'd1, 12'h108, 32'h0000_0200);

        drive(1'b0, 2'd3, 12'h000, 32'd0, 1'b0, 32'd0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule